// File: doc/BRIEF.md
# Barrel Shift Port Peripheral

This peripheral sits on the I/O port space of an 8-bit processor. It provides a multi-bit shift of a 16-bit value, which the processor would otherwise have to build from a chain of single-bit rotates. Software feeds bytes into a two-byte queue through a load port. It chooses a bit offset from 0 to 7 through an offset port. Reading a window port then returns an 8-bit slice of the queue, taken from the top byte and moved down by the chosen offset.

Sound and watchdog port numbers are decoded and accepted, but they leave the shifter untouched. A write to any port number the block does not know about is dropped, and an error output pulses for one cycle. The read data is combinational from the stored state, so the processor can read back in the cycle right after a write.

Top module: `bshift_port_top`

## Requirements
- R1: After reset the 16-bit queue and the 3-bit offset are zero: a window read returns 0x00 and the error output is low.
- R2: A write strobe on the load port (number 4) places the data byte in queue bits 15:8 and moves the old bits 15:8 into bits 7:0. The change is visible from the next clock.
- R3: A write strobe on the offset port (number 2) stores data bits 2:0 as the offset, and data bits 7:3 are ignored.
- R4: While the read strobe is high and the read port is the window port (number 3), the read data equals queue bits [15-offset : 8-offset], which is the queue shifted right by 8 minus the offset. In every other case the read data is 0x00.
- R5: With offset 0 the window is exactly queue bits 15:8. With offset 7 it is bits 8:1.
- R6: Writes to port numbers 3, 5 and 6 change neither the queue nor the offset, and they raise no error.
- R7: A write strobe on any port number other than 2, 3, 4, 5 or 6 changes no state. The error output is high in exactly the following cycle, and is low after every other cycle.
- R8: A read made in the same cycle as a load or offset write returns the value from before the write. A read in the next cycle returns the updated value.
- R9: The queue and offset change only on a write strobe with a matching port number. A port number of 4 or 2 presented without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_port | input | 8 | Port number of the write access |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rd_port | input | 8 | Port number of the read access |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Window byte on a window-port read, else zero |
| port_err | output | 1 | One-cycle pulse after a write to an undefined port |

## Verification
The assertions assume that the strobes and port numbers are stable and known around each rising edge, and that the processor performs at most one write per cycle. The bench drives every input just after the falling edge and holds it through the following rising edge, so each access is one clean cycle. The assertions also assume that a read and a write may coincide, so the stimulus mixes same-cycle read and write traffic deliberately. Reset is held for several cycles before any access, which lets the internal synchronizer release before the first strobe.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  // Decoded meaning of one write access
  typedef enum logic [2:0] {
    WCMD_NONE   = 3'd0,
    WCMD_LOAD   = 3'd1,
    WCMD_OFFSET = 3'd2,
    WCMD_QUIET  = 3'd3,
    WCMD_BAD    = 3'd4
  } wr_cmd_e;

endpackage

// File: rtl/bshift_wr_decode.sv
module bshift_wr_decode
  import bshift_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int LOAD_PORT   = 4,
  parameter int OFFSET_PORT = 2,
  parameter int QUIET_A     = 3,
  parameter int QUIET_B     = 5,
  parameter int QUIET_C     = 6
) (
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_port,
  output wr_cmd_e           cmd
);

  always_comb begin
    cmd = WCMD_NONE;
    if (wr_en) begin
      if (wr_port == PORT_W'(LOAD_PORT)) begin
        cmd = WCMD_LOAD;
      end else if (wr_port == PORT_W'(OFFSET_PORT)) begin
        cmd = WCMD_OFFSET;
      end else if ((wr_port == PORT_W'(QUIET_A)) ||
                   (wr_port == PORT_W'(QUIET_B)) ||
                   (wr_port == PORT_W'(QUIET_C))) begin
        cmd = WCMD_QUIET;
      end else begin
        cmd = WCMD_BAD;
      end
    end
  end

endmodule

// File: rtl/bshift_queue.sv
module bshift_queue #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2,
  localparam int Q_W   = DATA_W * STAGES,
  localparam int OFF_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [DATA_W-1:0] byte_in,
  input  logic             offset_en,
  input  logic [DATA_W-1:0] offset_in,
  output logic [Q_W-1:0]   q,
  output logic [OFF_W-1:0] off
);

  logic [DATA_W-1:0] stage_q [STAGES];
  logic [DATA_W-1:0] stage_d [STAGES];
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  off_d;

  // Next-state: each stage takes its upper neighbour, the top takes the new byte
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == STAGES - 1) begin : g_top
      always_comb stage_d[s] = load_en ? byte_in : stage_q[s];
    end else begin : g_low
      always_comb stage_d[s] = load_en ? stage_q[s+1] : stage_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (load_en) begin
        stage_q[s] <= stage_d[s];
      end
    end

    assign q[s*DATA_W +: DATA_W] = stage_q[s];
  end

  always_comb off_d = offset_en ? offset_in[OFF_W-1:0] : off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (offset_en) begin
      off_q <= off_d;
    end
  end

  assign off = off_q;

  // R2
  load_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (q[Q_W-1 -: DATA_W] == $past(byte_in)) &&
                (q[Q_W-DATA_W-1:0] == $past(q[Q_W-1:DATA_W])));

  // R3
  offset_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_en |=> off == $past(offset_in[OFF_W-1:0]));

  // R9
  queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(q));

  // R9
  offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !offset_en |=> $stable(off));

endmodule

// File: rtl/bshift_window.sv
module bshift_window #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2,
  localparam int Q_W   = DATA_W * STAGES,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int N_OFF = 1 << OFF_W
) (
  input  logic [Q_W-1:0]    q,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] win
);

  logic [DATA_W-1:0] cand [N_OFF];

  // Candidate k is the top byte moved down by k bits
  for (genvar k = 0; k < N_OFF; k++) begin : g_cand
    assign cand[k] = q[Q_W-DATA_W-k +: DATA_W];
  end

  assign win = cand[off];

endmodule

// File: rtl/bshift_err.sv
module bshift_err (
  input  logic clk,
  input  logic rst_n,
  input  logic bad_in,
  output logic err
);

  logic err_q;
  logic err_d;

  always_comb err_d = bad_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign err = err_q;

  // R7
  bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_in |=> err);

  // R7
  quiet_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_in |=> !err);

endmodule

// File: rtl/bshift_port_top.sv
module bshift_port_top
  import bshift_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int DATA_W      = 8,
  parameter int STAGES      = 2,
  parameter int LOAD_PORT   = 4,
  parameter int OFFSET_PORT = 2,
  parameter int WINDOW_PORT = 3,
  parameter int QUIET_A     = 3,
  parameter int QUIET_B     = 5,
  parameter int QUIET_C     = 6,
  localparam int Q_W        = DATA_W * STAGES,
  localparam int OFF_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] rd_port,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              port_err
);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  wr_cmd_e           cmd;
  logic [Q_W-1:0]    q;
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] win;
  logic              rd_hit;

  bshift_wr_decode #(
    .PORT_W(PORT_W), .LOAD_PORT(LOAD_PORT), .OFFSET_PORT(OFFSET_PORT),
    .QUIET_A(QUIET_A), .QUIET_B(QUIET_B), .QUIET_C(QUIET_C)
  ) u_decode (
    .wr_en  (wr_en),
    .wr_port(wr_port),
    .cmd    (cmd)
  );

  bshift_queue #(.DATA_W(DATA_W), .STAGES(STAGES)) u_queue (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (cmd == WCMD_LOAD),
    .byte_in  (wr_data),
    .offset_en(cmd == WCMD_OFFSET),
    .offset_in(wr_data),
    .q        (q),
    .off      (off)
  );

  bshift_window #(.DATA_W(DATA_W), .STAGES(STAGES)) u_window (
    .q  (q),
    .off(off),
    .win(win)
  );

  bshift_err u_err (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .bad_in(cmd == WCMD_BAD),
    .err   (port_err)
  );

  assign rd_hit  = rd_en && (rd_port == PORT_W'(WINDOW_PORT));
  assign rd_data = rd_hit ? win : '0;

  // R5
  top_byte_win_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_hit && off == '0) |-> rd_data == q[Q_W-1 -: DATA_W]);

  // R5
  low_edge_win_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_hit && off == OFF_W'(DATA_W-1)) |-> rd_data == q[DATA_W:1]);

  // R6
  quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd == WCMD_QUIET) |=> $stable(q) && $stable(off) && !port_err);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> (q == '0) && (off == '0) && !port_err);

endmodule

// File: tb/bshift_port_top_bench.sv
`timescale 1ns/1ps
module bshift_port_top_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] wr_port, wr_data, rd_port;
  logic       wr_en, rd_en;
  logic [7:0] rd_data;
  logic       port_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural reference state
  int mq   = 0;
  int moff = 0;
  bit merr = 0;

  always #2.5 clk = ~clk;

  bshift_port_top u_bshift_port_top (
    .clk(clk), .rst_n(rst_n), .wr_port(wr_port), .wr_data(wr_data),
    .wr_en(wr_en), .rd_port(rd_port), .rd_en(rd_en),
    .rd_data(rd_data), .port_err(port_err)
  );

  function automatic bit known_port(int p);
    return (p == 2) || (p == 3) || (p == 4) || (p == 5) || (p == 6);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, check before the rising edge,
  // then advance the reference model on the rising edge.
  task automatic cyc(int wp, int wd, bit we, int rp, bit re, string tag);
    int exp_rd;
    @(negedge clk);
    wr_port = 8'(wp); wr_data = 8'(wd); wr_en = we;
    rd_port = 8'(rp); rd_en = re;
    #1;
    exp_rd = (re && rp == 3) ? ((mq >> (8 - moff)) & 255) : 0;
    check(tag, "rd_data", int'(rd_data), exp_rd);
    check(tag, "port_err", int'(port_err), int'(merr));
    @(posedge clk);
    if (we && wp == 4) mq = ((wd & 255) << 8) | (mq >> 8);
    if (we && wp == 2) moff = wd & 7;
    merr = we && !known_port(wp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_port = '0; wr_data = '0; wr_en = 0; rd_port = '0; rd_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    cyc(0, 0, 0, 3, 1, "R1");
    // R2 / R5: loads, offset 0 shows the top byte
    cyc(4, 8'hA5, 1, 3, 1, "R8");
    cyc(0, 0, 0, 3, 1, "R2");
    cyc(4, 8'h3C, 1, 3, 1, "R2");
    cyc(0, 0, 0, 3, 1, "R5");
    // R3: upper data bits ignored, offset 7
    cyc(2, 8'hFF, 1, 3, 1, "R3");
    cyc(0, 0, 0, 3, 1, "R5");
    cyc(2, 8'hF4, 1, 3, 1, "R8");
    cyc(0, 0, 0, 3, 1, "R3");
    // R4: no strobe or other port gives zero
    cyc(0, 0, 0, 3, 0, "R4");
    cyc(0, 0, 0, 1, 1, "R4");
    // R6: quiet ports
    cyc(3, 8'h77, 1, 3, 1, "R6");
    cyc(5, 8'h11, 1, 3, 1, "R6");
    cyc(6, 8'h22, 1, 3, 1, "R6");
    cyc(0, 0, 0, 3, 1, "R6");
    // R7: undefined ports
    cyc(9, 8'h99, 1, 3, 1, "R7");
    cyc(0, 8'h55, 1, 3, 1, "R7");
    cyc(0, 0, 0, 3, 1, "R7");
    cyc(0, 0, 0, 3, 1, "R7");
    // R9: matching port without strobe
    cyc(4, 8'hEE, 0, 3, 1, "R9");
    cyc(2, 8'h01, 0, 3, 1, "R9");
    cyc(0, 0, 0, 3, 1, "R9");
    // R8: back-to-back loads with reads
    cyc(4, 8'h81, 1, 3, 1, "R8");
    cyc(4, 8'h42, 1, 3, 1, "R8");
    cyc(0, 0, 0, 3, 1, "R8");

    // Mixed traffic, compared every cycle (R4)
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 9);
      int wp  = (sel < 4) ? 4 : (sel < 6) ? 2 : (sel < 8) ? $urandom_range(3, 6)
                                                   : $urandom_range(0, 255);
      cyc(wp, $urandom_range(0, 255), $urandom_range(0, 3) != 0,
          ($urandom_range(0, 4) != 0) ? 3 : $urandom_range(0, 255),
          $urandom_range(0, 3) != 0, "R4");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule